// File: doc/BRIEF.md
# Cartridge Bank and Control Register File

This block is the register file of a banked flash cartridge on the expansion port of an 8-bit home computer. It watches CPU cycles in the IO1 page (an 8-bit address low byte qualified by an active-low page select and a read/write line). It holds two 8-bit bank registers, one for the lower 8 KiB ROM window and one for the upper 8 KiB ROM window, and an 8-bit control register. From these it produces the 8 KiB flash bank index for each window, two chip-level flash address bits, and enables for the three ROM windows.

The control register selects between two personalities. In run mode its upper bits are flash address lines and the SPI pins rest idle. In bitbang mode the same bits drive the SPI clock, data-in and chip select of the flash directly, every ROM window is switched off, and any read in the IO1 page returns the live SPI data-out level on data bit 7. Each rising edge of `clk` marks the end of a bus cycle, and writes are captured there. Only the control register has a reset. The bank registers keep their contents through reset, so software must load them after every reset.

Top module: `cart_regfile`

## Requirements
- R1: Register selection uses only `addr[2:0]`. Bits 7:3 are ignored, so the eight-register set repeats 32 times across the page.
- R2: A write at offset 0 loads the same byte V into both bank registers. The lower window then shows bank index 2V (`bank_lo` = {V,0}) and the upper window shows 2V+1 (`bank_hi` = {V,1}).
- R3: A write at offset 1 loads only the upper-window register. A write at offset 2 loads only the lower-window register.
- R4: A write at any offset from 4 to 7 loads the control register. In it, bit 0 = bitbang enable and bits 1/2/3 = disable the lower/upper/top ROM window when set. `win_en[0]`, `win_en[1]` and `win_en[2]` are the lower, upper and top window enables.
- R5: A low `rst_n` clears the control register to 0x00 at once. This gives run mode, all three windows enabled and `flash_hi_addr` = 0.
- R6: The bank registers keep their values through reset.
- R7: A cycle changes no register unless `io1_n` is low and `rw` is low (write) at the capturing edge. A write at offset 3 changes no register. Reads change no register.
- R8: In run mode (bit 0 = 0), `flash_hi_addr[0]` = control bit 4 and `flash_hi_addr[1]` = control bit 5. `spi_sck`, `spi_mosi` and `spi_cs_n` are all held at 1.
- R9: In bitbang mode (bit 0 = 1), `spi_sck` = bit 7, `spi_mosi` = bit 6 and `spi_cs_n` = bit 5. `flash_hi_addr` = 0 and `win_en` = 0.
- R10: In bitbang mode, an IO1 read at any address gives `rdata_oe` = 1 and `rdata` = {`spi_miso`,7'b0}, and it follows `spi_miso` with no clock delay. In run mode `rdata_oe` = 0 and `rdata` = 0.
- R11: A control-register write that changes bits 1 to 3 leaves both bank registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-cycle clock; the rising edge ends a cycle |
| rst_n | input | 1 | Active-low reset, clears the control register only |
| io1_n | input | 1 | Active-low IO1 page select |
| rw | input | 1 | 1 = CPU read, 0 = CPU write |
| addr | input | 8 | CPU address low byte |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | Read data for the IO1 page in bitbang mode |
| rdata_oe | output | 1 | This block drives the data bus |
| bank_lo | output | 9 | 8 KiB flash bank index for the lower window |
| bank_hi | output | 9 | 8 KiB flash bank index for the upper window |
| flash_hi_addr | output | 2 | Chip-level flash address bits (A22, A23) |
| win_en | output | 3 | ROM window enables: lower, upper, top |
| spi_sck | output | 1 | SPI clock to the flash |
| spi_mosi | output | 1 | SPI data into the flash |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_miso | input | 1 | SPI data out of the flash |

## Verification
A wrong bank register shows up on `bank_lo` or `bank_hi` on the first cycle after the write that caused it, and it stays there until the next load. Because reset cannot clear it, a stray load shows across a reset as well. A corrupted control register shows at once on several ports together: window enables, flash high bits and SPI pins. A lost mode bit swaps the whole pin personality. A fault in the read path, such as a registered `spi_miso` or non-zero low data bits, appears in the same cycle as the IO1 read.

// File: rtl/cart_reg_pkg.sv
package cart_reg_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned NWIN   = 3;
  localparam int unsigned CHIP_W = 2;

  // Register offsets inside one mirror of the set
  localparam logic [SEL_W-1:0] OFS_BOTH  = 3'd0;
  localparam logic [SEL_W-1:0] OFS_UPPER = 3'd1;
  localparam logic [SEL_W-1:0] OFS_LOWER = 3'd2;
  localparam logic [SEL_W-1:0] OFS_PROBE = 3'd3;

  // Control register field positions
  localparam int unsigned CB_BITBANG = 0;
  localparam int unsigned CB_WIN_DIS = 1;  // three bits: lower, upper, top
  localparam int unsigned CB_CHIP    = 4;  // two bits: A22, A23
  localparam int unsigned CB_SCS     = 5;
  localparam int unsigned CB_SDI     = 6;
  localparam int unsigned CB_SCK     = 7;
endpackage

// File: rtl/cart_io_decode.sv
module cart_io_decode #(
  parameter int unsigned ADDR_W = cart_reg_pkg::ADDR_W,
  parameter int unsigned SEL_W  = cart_reg_pkg::SEL_W
) (
  input  logic              io1_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_both,
  output logic              wr_upper,
  output logic              wr_lower,
  output logic              wr_ctrl,
  output logic              rd_page
);
  import cart_reg_pkg::*;

  localparam logic [ADDR_W-1:0] SEL_MASK = ADDR_W'((1 << SEL_W) - 1);

  logic [SEL_W-1:0] ofs;
  logic             wr_cyc;

  // upper address bits are masked away: the set mirrors across the page
  assign ofs      = SEL_W'(addr & SEL_MASK);
  assign wr_cyc   = !io1_n && !rw;
  assign rd_page  = !io1_n && rw;

  assign wr_both  = wr_cyc && (ofs == OFS_BOTH);
  assign wr_upper = wr_cyc && (ofs == OFS_UPPER);
  assign wr_lower = wr_cyc && (ofs == OFS_LOWER);
  // upper half of the set (offsets 4..7) all alias the control register
  assign wr_ctrl  = wr_cyc && ofs[SEL_W-1];
endmodule

// File: rtl/cart_bank_store.sv
module cart_bank_store #(
  parameter int unsigned DATA_W = cart_reg_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              wr_both,
  input  logic              wr_upper,
  input  logic              wr_lower,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] lower_val,
  output logic [DATA_W-1:0] upper_val
);
  localparam int unsigned NBANK = 2;

  logic [NBANK-1:0]             load;
  logic [NBANK-1:0][DATA_W-1:0] q;

  // index 0 = lower window, index 1 = upper window
  assign load = {wr_upper, wr_lower} | {NBANK{wr_both}};

  // deliberately no reset: contents survive a system reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < NBANK; i++) begin
      if (load[i]) q[i] <= wdata;
    end
  end

  assign lower_val = q[0];
  assign upper_val = q[1];
endmodule

// File: rtl/cart_ctrl_store.sv
module cart_ctrl_store #(
  parameter int unsigned DATA_W = cart_reg_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wdata;
  end
endmodule

// File: rtl/cart_pin_mux.sv
module cart_pin_mux #(
  parameter int unsigned DATA_W = cart_reg_pkg::DATA_W,
  parameter int unsigned NWIN   = cart_reg_pkg::NWIN,
  parameter int unsigned CHIP_W = cart_reg_pkg::CHIP_W
) (
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic [DATA_W-1:0] lower_val,
  input  logic [DATA_W-1:0] upper_val,
  input  logic              rd_page,
  input  logic              spi_miso,
  output logic [DATA_W:0]   bank_lo,
  output logic [DATA_W:0]   bank_hi,
  output logic [CHIP_W-1:0] flash_hi_addr,
  output logic [NWIN-1:0]   win_en,
  output logic              spi_sck,
  output logic              spi_mosi,
  output logic              spi_cs_n,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  import cart_reg_pkg::*;

  // 8 KiB bank index: even banks for the lower window, odd for the upper
  function automatic logic [DATA_W:0] bank_index(input logic [DATA_W-1:0] v,
                                                 input logic odd);
    return {v, odd};
  endfunction

  function automatic logic [DATA_W-1:0] probe_word(input logic bit_in);
    logic [DATA_W-1:0] w;
    w = '0;
    w[DATA_W-1] = bit_in;
    return w;
  endfunction

  logic bitbang;
  assign bitbang = ctrl_q[CB_BITBANG];

  assign bank_lo = bank_index(lower_val, 1'b0);
  assign bank_hi = bank_index(upper_val, 1'b1);

  // chip-level address bits only exist in run mode
  assign flash_hi_addr = bitbang ? '0 : ctrl_q[CB_CHIP +: CHIP_W];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign win_en[w] = !bitbang && !ctrl_q[CB_WIN_DIS + w];
  end

  // SPI pins idle high in run mode
  assign spi_sck  = bitbang ? ctrl_q[CB_SCK] : 1'b1;
  assign spi_mosi = bitbang ? ctrl_q[CB_SDI] : 1'b1;
  assign spi_cs_n = bitbang ? ctrl_q[CB_SCS] : 1'b1;

  assign rdata_oe = bitbang && rd_page;
  assign rdata    = rdata_oe ? probe_word(spi_miso) : '0;
endmodule

// File: rtl/cart_regfile.sv
module cart_regfile #(
  parameter int unsigned DATA_W = cart_reg_pkg::DATA_W,
  parameter int unsigned ADDR_W = cart_reg_pkg::ADDR_W,
  parameter int unsigned SEL_W  = cart_reg_pkg::SEL_W,
  parameter int unsigned NWIN   = cart_reg_pkg::NWIN,
  parameter int unsigned CHIP_W = cart_reg_pkg::CHIP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io1_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic [DATA_W:0]   bank_lo,
  output logic [DATA_W:0]   bank_hi,
  output logic [CHIP_W-1:0] flash_hi_addr,
  output logic [NWIN-1:0]   win_en,
  output logic              spi_sck,
  output logic              spi_mosi,
  output logic              spi_cs_n,
  input  logic              spi_miso
);
  // named internal events, visible to the bound checker
  logic              wr_both, wr_upper, wr_lower, wr_ctrl, rd_page;
  logic [DATA_W-1:0] lower_val, upper_val, ctrl_q;

  cart_io_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) i_decode (
    .io1_n   (io1_n),
    .rw      (rw),
    .addr    (addr),
    .wr_both (wr_both),
    .wr_upper(wr_upper),
    .wr_lower(wr_lower),
    .wr_ctrl (wr_ctrl),
    .rd_page (rd_page)
  );

  cart_bank_store #(.DATA_W(DATA_W)) i_banks (
    .clk      (clk),
    .wr_both  (wr_both),
    .wr_upper (wr_upper),
    .wr_lower (wr_lower),
    .wdata    (wdata),
    .lower_val(lower_val),
    .upper_val(upper_val)
  );

  cart_ctrl_store #(.DATA_W(DATA_W)) i_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ctrl(wr_ctrl),
    .wdata  (wdata),
    .ctrl_q (ctrl_q)
  );

  cart_pin_mux #(.DATA_W(DATA_W), .NWIN(NWIN), .CHIP_W(CHIP_W)) i_mux (
    .ctrl_q       (ctrl_q),
    .lower_val    (lower_val),
    .upper_val    (upper_val),
    .rd_page      (rd_page),
    .spi_miso     (spi_miso),
    .bank_lo      (bank_lo),
    .bank_hi      (bank_hi),
    .flash_hi_addr(flash_hi_addr),
    .win_en       (win_en),
    .spi_sck      (spi_sck),
    .spi_mosi     (spi_mosi),
    .spi_cs_n     (spi_cs_n),
    .rdata        (rdata),
    .rdata_oe     (rdata_oe)
  );
endmodule

// File: rtl/cart_regfile_chk.sv
module cart_regfile_chk #(
  parameter int unsigned DATA_W = cart_reg_pkg::DATA_W,
  parameter int unsigned ADDR_W = cart_reg_pkg::ADDR_W,
  parameter int unsigned NWIN   = cart_reg_pkg::NWIN
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io1_n,
  input logic              rw,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              wr_both,
  input logic              wr_upper,
  input logic              wr_lower,
  input logic              wr_ctrl,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W:0]   bank_lo,
  input logic [DATA_W:0]   bank_hi,
  input logic [NWIN-1:0]   win_en,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_oe,
  input logic              spi_miso
);
  // R1: at most one register target per cycle
  a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_both, wr_upper, wr_lower, wr_ctrl}));

  // R2: common write lands in both windows with the right parity
  a_r2_both_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    wr_both |=> (bank_lo == {$past(wdata), 1'b0}) && (bank_hi == {$past(wdata), 1'b1}));

  // R3: single-window writes leave the other window alone
  a_r3_lower_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_upper |=> $stable(bank_lo));
  a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lower |=> $stable(bank_hi));

  // R5: control register comes out of reset cleared
  a_r5_ctrl_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctrl_q == '0));

  // R7: a write at offset 3 touches nothing
  a_r7_probe_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (!io1_n && !rw && (addr[2:0] == 3'd3)) |=>
      $stable(bank_lo) && $stable(bank_hi) && $stable(ctrl_q));

  // R9: bitbang mode turns every ROM window off
  a_r9_windows_off: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[0] |-> (win_en == '0));

  // R10: bitbang read returns the live SPI output on bit 7
  a_r10_probe_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && !io1_n && rw) |->
      rdata_oe && (rdata[DATA_W-1] == spi_miso) && (rdata[DATA_W-2:0] == '0));

  // R11: control writes never disturb the bank registers
  a_r11_banks_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> $stable(bank_lo) && $stable(bank_hi));
endmodule

bind cart_regfile cart_regfile_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NWIN(NWIN)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .io1_n   (io1_n),
  .rw      (rw),
  .addr    (addr),
  .wdata   (wdata),
  .wr_both (wr_both),
  .wr_upper(wr_upper),
  .wr_lower(wr_lower),
  .wr_ctrl (wr_ctrl),
  .ctrl_q  (ctrl_q),
  .bank_lo (bank_lo),
  .bank_hi (bank_hi),
  .win_en  (win_en),
  .rdata   (rdata),
  .rdata_oe(rdata_oe),
  .spi_miso(spi_miso)
);

// File: tb/test_cart_regfile.sv
`timescale 1ns/1ps
module test_cart_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io1_n = 1'b1;
  logic       rw = 1'b1;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       spi_miso = 1'b0;
  logic [7:0] rdata;
  logic       rdata_oe;
  logic [8:0] bank_lo, bank_hi;
  logic [1:0] flash_hi_addr;
  logic [2:0] win_en;
  logic       spi_sck, spi_mosi, spi_cs_n;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  // bench model of the registers
  logic [7:0] m_lo, m_hi, m_ctrl;
  bit         m_banks_known = 1'b0;

  always #4 clk = ~clk;

  cart_regfile i_cart_regfile (
    .clk(clk), .rst_n(rst_n), .io1_n(io1_n), .rw(rw), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe), .bank_lo(bank_lo), .bank_hi(bank_hi),
    .flash_hi_addr(flash_hi_addr), .win_en(win_en), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    bit bb;
    bb = m_ctrl[0];
    if (m_banks_known) begin
      chk(req, "bank_lo", int'(bank_lo), int'(m_lo) * 2);
      chk(req, "bank_hi", int'(bank_hi), int'(m_hi) * 2 + 1);
    end
    chk(req, "flash_hi_addr", int'(flash_hi_addr), bb ? 0 : int'(m_ctrl[5:4]));
    chk(req, "win_en", int'(win_en), bb ? 0 : int'(~m_ctrl[3:1] & 3'b111));
    chk(req, "spi_sck", int'(spi_sck), bb ? int'(m_ctrl[7]) : 1);
    chk(req, "spi_mosi", int'(spi_mosi), bb ? int'(m_ctrl[6]) : 1);
    chk(req, "spi_cs_n", int'(spi_cs_n), bb ? int'(m_ctrl[5]) : 1);
  endtask

  // one bus cycle; sel=0 leaves IO1 unselected
  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d, input bit sel);
    @(negedge clk);
    io1_n = !sel; rw = 1'b0; addr = a; wdata = d;
    @(posedge clk);
    #1;
    io1_n = 1'b1; rw = 1'b1;
    if (sel) begin
      case (a[2:0])
        3'd0: begin m_lo = d; m_hi = d; end
        3'd1: m_hi = d;
        3'd2: m_lo = d;
        3'd3: ;
        default: m_ctrl = d;
      endcase
    end
    #2;
  endtask

  task automatic bus_rd(input logic [7:0] a, input string req);
    @(negedge clk);
    io1_n = 1'b0; rw = 1'b1; addr = a;
    #1;
    chk(req, "rdata_oe", int'(rdata_oe), int'(m_ctrl[0]));
    chk(req, "rdata", int'(rdata), m_ctrl[0] ? int'(spi_miso) * 128 : 0);
    @(posedge clk);
    #1;
    io1_n = 1'b1;
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_ctrl = 8'h00;
    #2;
    check_all("R5");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_ctrl = 8'h00; m_lo = '0; m_hi = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R5: state straight out of reset
    check_all("R5");
    chk("R5", "win_en all on", int'(win_en), 7);

    // R3: single-window writes
    bus_wr(8'h01, 8'h3C, 1'b1);
    bus_wr(8'h02, 8'hC3, 1'b1);
    m_banks_known = 1'b1;
    check_all("R3");
    bus_wr(8'h01, 8'h7E, 1'b1);
    check_all("R3");
    bus_wr(8'h02, 8'h81, 1'b1);
    check_all("R3");

    // R6 and R5: reset mid-run with a busy control register
    bus_wr(8'h04, 8'h35, 1'b1);
    check_all("R4");
    do_reset();
    check_all("R6");

    // R1: every address in the page, mirrors included
    for (int a = 0; a < 256; a++) begin
      bus_wr(8'(a), 8'((a * 37 + 11) & 8'hFE), 1'b1);
      check_all("R1");
    end

    // R2: common write with every data value, spread over mirrors
    for (int d = 0; d < 256; d++) begin
      bus_wr({5'(d), 3'd0}, 8'(d), 1'b1);
      check_all("R2");
    end

    // R4, R8 and R9: every control value written at offsets 4..7
    for (int c = 0; c < 256; c++) begin
      bus_wr(8'(4 + (c & 3) + 8 * (c >> 2)), 8'(c), 1'b1);
      check_all(c[0] ? "R9" : "R8");
      check_all("R4");
    end

    // R7: unselected writes, probe-offset writes and reads change nothing
    bus_wr(8'h00, 8'h55, 1'b1);
    bus_wr(8'h04, 8'h20, 1'b1);
    for (int a = 0; a < 8; a++) begin
      bus_wr(8'(a), 8'hA5, 1'b0);
      check_all("R7");
    end
    for (int k = 0; k < 32; k++) begin
      bus_wr({5'(k), 3'd3}, 8'(k * 9 + 1), 1'b1);
      check_all("R7");
    end
    for (int a = 0; a < 8; a++) begin
      bus_rd(8'(a), "R10");
      check_all("R7");
    end

    // R10: bitbang reads at every address with both data-out levels
    bus_wr(8'h07, 8'hEF, 1'b1);
    for (int a = 0; a < 256; a++) begin
      spi_miso = a[0] ^ a[5];
      bus_rd(8'(a), "R10");
    end
    // R10: read follows data-out with no clock delay
    @(negedge clk);
    io1_n = 1'b0; rw = 1'b1; addr = 8'h03;
    spi_miso = 1'b0; #1;
    chk("R10", "live low", int'(rdata), 0);
    spi_miso = 1'b1; #1;
    chk("R10", "live high", int'(rdata), 128);
    @(posedge clk); #1;
    io1_n = 1'b1;
    check_all("R7");

    // R11: toggling window disables keeps both bank registers
    bus_wr(8'h01, 8'h9A, 1'b1);
    bus_wr(8'h02, 8'h16, 1'b1);
    for (int w = 0; w < 8; w++) begin
      bus_wr(8'h05, 8'(w << 1), 1'b1);
      check_all("R11");
      chk("R11", "bank_lo kept", int'(bank_lo), 9'h02C);
      chk("R11", "bank_hi kept", int'(bank_hi), 9'h135);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule